// File: doc/BRIEF.md
# Fractional-Rate Serial Clock Generator

This block derives the serial clock of a synchronous serial port from a fast reference clock. Instead of an integer divider it uses a phase accumulator: every reference cycle a programmable increment is added. Crossing half scale produces the leading (active-going) clock edge, and a wrap produces the trailing (idle-going) edge. An increment of 2048 gives the fastest rate, half the reference frequency. Smaller increments give proportionally slower and possibly non-integer average rates.

Alongside the clock it emits two single-cycle strobes for the data path. The launch strobe tells the shifter to present the next output bit. The sample strobe tells it to capture the input line. Whether launching happens on the leading or the trailing edge is selectable. The idle level of the clock is programmable. The clock can be gated off while no slave select is asserted. A run input from the transfer sequencer starts and stops the generator. Dropping it returns the clock to idle and rewinds the accumulator, so every transfer starts with the same phase.

Top module: `hsclk_gen`

## Requirements
- R1: The accumulator is 12 bits wide, counts modulo 4096 and starts from 0 when a run begins. A step that moves it from below 2048 to 2048 or above, without wrapping, makes a leading edge. A step whose sum reaches 4096 makes a trailing edge. Without the loop-reset option the remainder is kept. For example, increment 1500 over 30 cycles gives 11 leading edges.
- R2: The 16-bit frequency word is used as the increment, saturated at 2048. A word of 0 gives no edges and no strobes.
- R3: When the double-rate control is set, the increment is twice the frequency word, still saturated at 2048.
- R4: When the loop-reset control is set, the accumulator becomes 0 at each wrap instead of keeping the remainder. For example, increment 1500 then gives one clock period every 3 cycles.
- R5: The clock output sits at the idle polarity input whenever no active half-period is in progress. A leading edge drives it to the inverse of that level.
- R6: Each edge appears on the outputs one reference cycle after the clock edge that processed the step. While run is low the clock is idle, no strobe is issued and the accumulator is held at 0. The first leading edge of a run therefore appears after ceil(2048/increment) cycles.
- R7: With launch-on-leading selected (value 1), launch pulses with each leading edge and sample with each trailing edge. With the select at 0, sample pulses with the leading edge and launch with the trailing edge.
- R8: When the gate control is set and no bit of the slave-select vector is 1, the clock output stays at the idle level. The strobes continue as if ungated.
- R9: Launch and sample each last one cycle and are never high in the same cycle.
- R10: During and directly after reset the clock equals the idle polarity and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_i | input | 1 | Generator enable from the transfer sequencer |
| freq_word_i | input | 16 | Frequency control word (increment) |
| dbl_i | input | 1 | Double-rate select |
| loop_rst_i | input | 1 | Clear accumulator on wrap |
| cpol_i | input | 1 | Idle level of the serial clock |
| launch_lead_i | input | 1 | 1: launch on leading edge; 0: sample on leading edge |
| gate_en_i | input | 1 | Stop clock while no slave select is active |
| ss_act_i | input | 8 | Active slave selects, one bit each |
| sclk_o | output | 1 | Serial clock |
| launch_o | output | 1 | Launch strobe for outgoing data |
| sample_o | output | 1 | Sample strobe for incoming data |

## Verification
The cycle-level properties are checked on every cycle:
- strobe exclusivity;
- the idle state after run drops;
- the idle clock under gating;
- a clock toggle accompanying every ungated strobe;
- the clock level that goes with each strobe for the chosen edge select.

Rate properties span many cycles and can only be shown by the bench's scenarios. These are the edge counts for a given increment, saturation, doubling, remainder keeping versus loop reset, and the delay to the first edge after a run starts. The bench counts edges and strobes over fixed windows and compares them with counts derived by hand from the accumulator arithmetic.

// File: rtl/hsclk_pkg.sv
package hsclk_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_LEAD  = 2'd1,
    EV_TRAIL = 2'd2
  } hsclk_ev_e;
endpackage

// File: rtl/hsclk_rst_sync.sv
module hsclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hsclk_incr.sv
module hsclk_incr #(
  parameter int FW    = 16,
  parameter int ACC_W = 12
) (
  input  logic [FW-1:0]    freq_word,
  input  logic             dbl,
  output logic [ACC_W-1:0] incr
);
  localparam int HALF = 1 << (ACC_W - 1);

  logic [FW:0] scaled;

  always_comb begin
    scaled = dbl ? {freq_word, 1'b0} : {1'b0, freq_word};
    if (scaled > (FW+1)'(HALF)) incr = ACC_W'(HALF);
    else                        incr = scaled[ACC_W-1:0];
  end
endmodule

// File: rtl/hsclk_accum.sv
module hsclk_accum
  import hsclk_pkg::*;
#(
  parameter int ACC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             loop_rst,
  input  logic [ACC_W-1:0] incr,
  output hsclk_ev_e        ev
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;
  logic             wrap, cross_half;

  always_comb begin
    sum        = {1'b0, acc_q} + {1'b0, incr};
    wrap       = sum[ACC_W];
    cross_half = !acc_q[ACC_W-1] && sum[ACC_W-1] && !wrap;

    if (!run)                 ev = EV_NONE;
    else if (wrap)            ev = EV_TRAIL;
    else if (cross_half)      ev = EV_LEAD;
    else                      ev = EV_NONE;

    if (!run)                 acc_d = '0;
    else if (wrap && loop_rst) acc_d = '0;
    else                      acc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/hsclk_edge.sv
module hsclk_edge
  import hsclk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  hsclk_ev_e ev,
  input  logic      launch_lead,
  output logic      phase,
  output logic      launch,
  output logic      sample
);
  logic phase_q, phase_d;
  logic launch_q, launch_d;
  logic sample_q, sample_d;

  always_comb begin
    phase_d  = phase_q;
    launch_d = 1'b0;
    sample_d = 1'b0;
    if (!run) begin
      phase_d = 1'b0;
    end else begin
      case (ev)
        EV_LEAD: begin
          phase_d  = 1'b1;
          launch_d = launch_lead;
          sample_d = !launch_lead;
        end
        EV_TRAIL: begin
          phase_d  = 1'b0;
          launch_d = !launch_lead;
          sample_d = launch_lead;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= 1'b0;
      launch_q <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      launch_q <= launch_d;
      sample_q <= sample_d;
    end
  end

  assign phase  = phase_q;
  assign launch = launch_q;
  assign sample = sample_q;
endmodule

// File: rtl/hsclk_gen.sv
module hsclk_gen
  import hsclk_pkg::*;
#(
  parameter int FW    = 16,
  parameter int ACC_W = 12,
  parameter int NSS   = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  logic [FW-1:0]  freq_word_i,
  input  logic           dbl_i,
  input  logic           loop_rst_i,
  input  logic           cpol_i,
  input  logic           launch_lead_i,
  input  logic           gate_en_i,
  input  logic [NSS-1:0] ss_act_i,
  output logic           sclk_o,
  output logic           launch_o,
  output logic           sample_o
);
  logic             rst_n_s;
  logic [ACC_W-1:0] incr;
  hsclk_ev_e        ev;
  logic             phase;
  logic             gated;

  hsclk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  hsclk_incr #(.FW(FW), .ACC_W(ACC_W)) u_incr (
    .freq_word (freq_word_i),
    .dbl       (dbl_i),
    .incr      (incr)
  );

  hsclk_accum #(.ACC_W(ACC_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .run      (run_i),
    .loop_rst (loop_rst_i),
    .incr     (incr),
    .ev       (ev)
  );

  hsclk_edge u_edge (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .run         (run_i),
    .ev          (ev),
    .launch_lead (launch_lead_i),
    .phase       (phase),
    .launch      (launch_o),
    .sample      (sample_o)
  );

  assign gated  = gate_en_i && (ss_act_i == '0);
  assign sclk_o = cpol_i ^ (phase && !gated);
endmodule

// File: rtl/hsclk_gen_chk.sv
module hsclk_gen_chk #(
  parameter int NSS = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           run_i,
  input logic           cpol_i,
  input logic           launch_lead_i,
  input logic           gate_en_i,
  input logic [NSS-1:0] ss_act_i,
  input logic           sclk_o,
  input logic           launch_o,
  input logic           sample_o
);
  logic past_ok;
  logic gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assign gated = gate_en_i && (ss_act_i == '0);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch_o && sample_o)); // R9

  AST_OFF_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !run_i |=> !launch_o && !sample_o); // R6

  AST_OFF_IDLE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !run_i |=> sclk_o == cpol_i); // R5

  AST_GATED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    gated |-> sclk_o == cpol_i); // R8

  AST_STROBE_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && (launch_o || sample_o) && !gated && !$past(gated) && $stable(cpol_i)
      |-> sclk_o != $past(sclk_o)); // R1

  AST_LAUNCH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && launch_o && !gated && $stable(launch_lead_i)
      |-> sclk_o == (launch_lead_i ? !cpol_i : cpol_i)); // R7

  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(launch_o) && $past(run_i) && run_i && $stable(launch_lead_i)
      |-> !launch_o || $past(launch_o) == 1'b0); // R9
endmodule

bind hsclk_gen hsclk_gen_chk #(.NSS(NSS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .run_i         (run_i),
  .cpol_i        (cpol_i),
  .launch_lead_i (launch_lead_i),
  .gate_en_i     (gate_en_i),
  .ss_act_i      (ss_act_i),
  .sclk_o        (sclk_o),
  .launch_o      (launch_o),
  .sample_o      (sample_o)
);

// File: tb/hsclk_gen_tb.sv
module hsclk_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  typedef struct packed {
    logic [15:0] word;
    logic        dbl;
    logic        rol;
    logic        lead_launch;
    logic [7:0]  ncyc;
    logic [7:0]  exp_rise;
    logic [7:0]  exp_launch;
    logic [7:0]  exp_sample;
  } vec_t;

  // R1 R2 R3 R4 R7: counts derived from modulo-4096 arithmetic, half scale 2048
  localparam vec_t VECS [NVEC] = '{
    '{16'd2048, 1'b0, 1'b0, 1'b1, 8'd40, 8'd20, 8'd20, 8'd20},
    '{16'd1024, 1'b0, 1'b0, 1'b0, 8'd40, 8'd10, 8'd10, 8'd10},
    '{16'd3000, 1'b0, 1'b0, 1'b1, 8'd40, 8'd20, 8'd20, 8'd20},
    '{16'd1024, 1'b1, 1'b0, 1'b1, 8'd40, 8'd20, 8'd20, 8'd20},
    '{16'd1500, 1'b0, 1'b0, 1'b1, 8'd30, 8'd11, 8'd11, 8'd10},
    '{16'd1500, 1'b0, 1'b0, 1'b0, 8'd30, 8'd11, 8'd10, 8'd11},
    '{16'd1500, 1'b0, 1'b1, 1'b1, 8'd30, 8'd10, 8'd10, 8'd10},
    '{16'd0,    1'b0, 1'b0, 1'b1, 8'd20, 8'd0,  8'd0,  8'd0}
  };

  logic        clk;
  logic        rst_n;
  logic        run_i;
  logic [15:0] freq_word_i;
  logic        dbl_i;
  logic        loop_rst_i;
  logic        cpol_i;
  logic        launch_lead_i;
  logic        gate_en_i;
  logic [7:0]  ss_act_i;
  logic        sclk_o;
  logic        launch_o;
  logic        sample_o;

  int checks;
  int errors;
  bit done;
  int n_rise, n_fall, n_launch, n_sample, n_both;

  hsclk_gen dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_i         (run_i),
    .freq_word_i   (freq_word_i),
    .dbl_i         (dbl_i),
    .loop_rst_i    (loop_rst_i),
    .cpol_i        (cpol_i),
    .launch_lead_i (launch_lead_i),
    .gate_en_i     (gate_en_i),
    .ss_act_i      (ss_act_i),
    .sclk_o        (sclk_o),
    .launch_o      (launch_o),
    .sample_o      (sample_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // enable for n cycles, sampling after each edge; then disable one cycle
  task automatic run_cycles(input int n);
    logic prev;
    prev = sclk_o;
    n_rise = 0; n_fall = 0; n_launch = 0; n_sample = 0; n_both = 0;
    run_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (!prev && sclk_o) n_rise++;
      if (prev && !sclk_o) n_fall++;
      if (launch_o) n_launch++;
      if (sample_o) n_sample++;
      if (launch_o && sample_o) n_both++;
      prev = sclk_o;
    end
    run_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic s1, s2;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; run_i = 1'b0; freq_word_i = 16'd0; dbl_i = 1'b0;
    loop_rst_i = 1'b0; cpol_i = 1'b0; launch_lead_i = 1'b1;
    gate_en_i = 1'b0; ss_act_i = 8'h01;

    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10", sclk_o, 0, "sclk in reset");
    check("R10", launch_o | sample_o, 0, "strobes in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", sclk_o, 0, "sclk after reset");
    check("R10", launch_o | sample_o, 0, "strobes after reset");

    // table of rate vectors
    for (int v = 0; v < NVEC; v++) begin
      freq_word_i   = VECS[v].word;
      dbl_i         = VECS[v].dbl;
      loop_rst_i    = VECS[v].rol;
      launch_lead_i = VECS[v].lead_launch;
      run_cycles(int'(VECS[v].ncyc));
      check("R1", n_rise, int'(VECS[v].exp_rise), $sformatf("vec %0d leading edges", v));
      check("R7", n_launch, int'(VECS[v].exp_launch), $sformatf("vec %0d launch count", v));
      check("R7", n_sample, int'(VECS[v].exp_sample), $sformatf("vec %0d sample count", v));
      check("R9", n_both, 0, $sformatf("vec %0d overlapping strobes", v));
      check("R6", sclk_o, 0, $sformatf("vec %0d idle after run", v));
      check("R6", launch_o | sample_o, 0, $sformatf("vec %0d no strobe after run", v));
    end
    loop_rst_i = 1'b0; dbl_i = 1'b0; launch_lead_i = 1'b1;

    // R6: first leading edge timing, increment 1024 -> second cycle
    freq_word_i = 16'd1024;
    run_i = 1'b1;
    @(posedge clk); @(negedge clk); s1 = sclk_o;
    @(posedge clk); @(negedge clk); s2 = sclk_o;
    run_i = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R6", s1, 0, "sclk after first step");
    check("R6", s2, 1, "sclk after second step");

    // R6: run held low, no activity at full rate
    freq_word_i = 16'd2048;
    n_launch = 0; n_rise = 0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); @(negedge clk);
      if (launch_o || sample_o) n_launch++;
      if (sclk_o) n_rise++;
    end
    check("R6", n_launch, 0, "strobes while run low");
    check("R6", n_rise, 0, "sclk active while run low");

    // R6: restart rewinds accumulator (1500: lead on step 2 each time)
    freq_word_i = 16'd1500;
    run_cycles(1);
    run_cycles(2);
    check("R6", n_rise, 1, "lead after restart at step 2");
    run_cycles(1);
    check("R6", n_rise, 0, "no lead on single step after restart");

    // R5: idle polarity high
    cpol_i = 1'b1;
    @(negedge clk);
    check("R5", sclk_o, 1, "idle high");
    freq_word_i = 16'd2048;
    run_i = 1'b1;
    @(posedge clk); @(negedge clk); s1 = sclk_o;
    @(posedge clk); @(negedge clk); s2 = sclk_o;
    run_i = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R5", s1, 0, "active level with high idle");
    check("R5", s2, 1, "return to high idle");
    check("R5", sclk_o, 1, "idle high after run");
    cpol_i = 1'b0;

    // R8: gating with no select active
    gate_en_i = 1'b1;
    ss_act_i = 8'h00;
    run_cycles(20);
    check("R8", n_rise, 0, "gated sclk edges");
    check("R8", n_launch, 10, "strobes continue while gated");
    ss_act_i = 8'h80;
    run_cycles(20);
    check("R8", n_rise, 10, "gate open with select active");
    gate_en_i = 1'b0;
    ss_act_i = 8'h00;
    run_cycles(20);
    check("R8", n_rise, 10, "gate disabled");

    // R2 R3: doubling saturates
    freq_word_i = 16'd1500;
    dbl_i = 1'b1;
    run_cycles(20);
    check("R3", n_rise, 10, "doubled word saturates at 2048");
    dbl_i = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule